// File: doc/BRIEF.md
# Seconds Watchdog Timer

This block is a watchdog timer programmed through three byte-wide registers selected by an 8-bit address: a counter register, a control register and a status register. A prescaler divides the system clock down to one tick per second. In minute mode a second divider turns sixty of those ticks into one. Software starts the watchdog by writing a nonzero count, between 1 and 255 units, to the counter register. It keeps the watchdog alive by writing that count again before the count runs out, and it stops the watchdog by writing zero. The counter register is the live countdown, so a read returns the time remaining.

When the count reaches zero the block sets a sticky expiry flag and drives an active-low pulse on its timeout output. A control bit can also route that pulse onto an active-low keyboard-reset output. Keyboard and mouse activity inputs can reload the last programmed count, and each source has its own enable. A separate control bit makes keyboard activity stop the watchdog instead.

Top module: `sec_watchdog`

## Requirements
- R1: After reset all three registers read 0x00, and `timeoutN` and `kbdRstN` are both high.
- R2: A read of the counter register returns the remaining count. Once a value is loaded, the count drops by one every `CLKS_PER_SEC` clocks.
- R3: Writing 0x00 to the counter register stops the watchdog. The count stays 0 and no pulse follows.
- R4: A count of N written at clock edge E reaches 0 at edge E + N*`CLKS_PER_SEC` (seconds mode). At that edge, status bit 4 becomes 1, and the count then stays at 0.
- R5: `timeoutN` goes low at the expiry edge and stays low for exactly `PULSE_CLKS` clocks.
- R6: Status bit 4 is cleared by writing the status register with bit 4 = 0, or by loading a nonzero count. Writing bit 4 = 1 does not set it.
- R7: When control bit 1 is 1, `kbdRstN` carries the same low pulse as `timeoutN`. When control bit 1 is 0, `kbdRstN` stays high.
- R8: Writing a nonzero count while the watchdog is running reloads the count and restarts the prescaler, so expiry moves to N*`CLKS_PER_SEC` clocks after the rewrite.
- R9: When control bit 3 is 1, one count unit is 60*`CLKS_PER_SEC` clocks.
- R10: Status bit 6 enables keyboard reload and status bit 7 enables mouse reload. An enabled event while the count is nonzero reloads the last nonzero value written, with the same timing as a write. An event whose enable is 0 has no effect.
- R11: When control bit 2 is 1, a keyboard event stops the watchdog. This takes priority over a keyboard reload.
- R12: The register addresses are parameters, with defaults counter 0xF6, control 0xF5 and status 0xF7. The control register reads back the byte written to it. Reads of any other address return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 8 | Register address for reads and writes |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Read data for `regAddr` (combinational) |
| kbdEvent | input | 1 | One-clock keyboard activity pulse |
| mouseEvent | input | 1 | One-clock mouse activity pulse |
| timeoutN | output | 1 | Active-low expiry pulse |
| kbdRstN | output | 1 | Active-low keyboard-reset pulse when routing is enabled |

## Verification
The embedded assertions check every cycle that:
- the count only holds or drops by one between loads;
- a stopped count stays at zero;
- a nonzero load lands in the counter and clears the expiry flag;
- the keyboard-reset line is never low outside a timeout pulse;
- the expiry flag rises together with the pulse.

Only the bench scenarios can show:
- exact expiry cycles in second and minute units;
- the pulse width;
- the reload timing after keepalive writes and after input events;
- that disabled events and writes of 1 to the status flag leave the count and status unchanged.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  // Strobes and settings passed from the register control to the datapath
  typedef struct packed {
    logic       load;      // counter register written
    logic [7:0] loadVal;   // value written
    logic       stop;      // keyboard-stop event
    logic       reload;    // enabled activity event
    logic       clrFlag;   // status written with bit 4 = 0
    logic       minUnits;  // one unit = 60 seconds
    logic       routeKbd;  // mirror pulse onto keyboard reset
  } wdtStrobe_t;

  localparam int unsigned SECS_PER_MIN = 60;
endpackage

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
#(
  parameter logic [7:0] TMO_ADDR = 8'hF6,
  parameter logic [7:0] CTL_ADDR = 8'hF5,
  parameter logic [7:0] STS_ADDR = 8'hF7
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWr,
  input  logic [7:0] regAddr,
  input  logic [7:0] regWdata,
  output logic [7:0] regRdata,
  input  logic       kbdEvent,
  input  logic       mouseEvent,
  input  logic [7:0] countIn,
  input  logic       expiredIn,
  output wdtStrobe_t strb
);
  logic [7:0] ctlReg;
  logic       kbdEn, mouseEn;
  logic       wrTmo, wrCtl, wrSts;

  assign wrTmo = regWr && (regAddr == TMO_ADDR);
  assign wrCtl = regWr && (regAddr == CTL_ADDR);
  assign wrSts = regWr && (regAddr == STS_ADDR);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctlReg  <= '0;
      kbdEn   <= 1'b0;
      mouseEn <= 1'b0;
    end else begin
      if (wrCtl) ctlReg <= regWdata;
      if (wrSts) begin
        mouseEn <= regWdata[7];
        kbdEn   <= regWdata[6];
      end
    end
  end

  always_comb begin
    strb          = '0;
    strb.load     = wrTmo;
    strb.loadVal  = regWdata;
    strb.stop     = kbdEvent && ctlReg[2] && !wrTmo;
    strb.reload   = ((kbdEvent && kbdEn) || (mouseEvent && mouseEn)) && !wrTmo && !strb.stop;
    strb.clrFlag  = wrSts && !regWdata[4];
    strb.minUnits = ctlReg[3];
    strb.routeKbd = ctlReg[1];
  end

  always_comb begin
    unique case (regAddr)
      TMO_ADDR: regRdata = countIn;
      CTL_ADDR: regRdata = ctlReg;
      STS_ADDR: regRdata = {mouseEn, kbdEn, 1'b0, expiredIn, 4'b0000};
      default:  regRdata = 8'h00;
    endcase
  end

  // R11: a keyboard stop never coexists with a reload request
  p_stop_wins_r11: assert property (@(posedge clk) disable iff (!rstN)
    (kbdEvent && ctlReg[2] && !wrTmo) |-> !strb.reload);
endmodule

// File: rtl/wdt_datapath.sv
module wdt_datapath
  import wdt_pkg::*;
#(
  parameter int unsigned CLKS_PER_SEC = 32768,
  parameter int unsigned PULSE_CLKS   = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  wdtStrobe_t strb,
  output logic [7:0] count,
  output logic       expired,
  output logic       timeoutN,
  output logic       kbdRstN
);
  localparam int unsigned PW = $clog2(CLKS_PER_SEC + 1);
  localparam int unsigned MW = $clog2(SECS_PER_MIN + 1);
  localparam int unsigned QW = $clog2(PULSE_CLKS + 1);

  logic [PW-1:0] presc;
  logic [MW-1:0] minCnt;
  logic [QW-1:0] pulseCnt;
  logic [7:0]    reloadVal;
  logic          running, restart, secTick, unitTick, fire;

  assign running  = (count != 8'd0);
  assign restart  = strb.load || strb.stop || strb.reload;
  assign secTick  = running && (presc == PW'(CLKS_PER_SEC - 1));
  assign unitTick = secTick && (!strb.minUnits || (minCnt == MW'(SECS_PER_MIN - 1)));
  assign fire     = unitTick && (count == 8'd1) && !restart;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      presc     <= '0;
      minCnt    <= '0;
      count     <= '0;
      reloadVal <= '0;
      expired   <= 1'b0;
      pulseCnt  <= '0;
    end else begin
      if (restart || !running || secTick) presc <= '0;
      else                                presc <= presc + 1'b1;

      if (restart || !running) minCnt <= '0;
      else if (secTick)        minCnt <= (minCnt == MW'(SECS_PER_MIN - 1)) ? '0 : minCnt + 1'b1;

      if (strb.load) begin
        count <= strb.loadVal;
        if (strb.loadVal != 8'd0) reloadVal <= strb.loadVal;
      end else if (strb.stop) begin
        count <= 8'd0;
      end else if (strb.reload && running) begin
        count <= reloadVal;
      end else if (unitTick) begin
        count <= count - 8'd1;
      end

      if (fire)                                              expired <= 1'b1;
      else if ((strb.load && strb.loadVal != 8'd0) || strb.clrFlag) expired <= 1'b0;

      if (fire)                  pulseCnt <= QW'(PULSE_CLKS);
      else if (pulseCnt != '0)   pulseCnt <= pulseCnt - 1'b1;
    end
  end

  assign timeoutN = (pulseCnt == '0);
  assign kbdRstN  = !((pulseCnt != '0) && strb.routeKbd);

  // R2: between loads the count holds or drops by exactly one
  p_count_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!restart && count != 8'd0) |=> (count == $past(count) || count == $past(count) - 8'd1));
  // R3: a stopped counter stays at zero without a load
  p_zero_holds_r3: assert property (@(posedge clk) disable iff (!rstN)
    (count == 8'd0 && !strb.load) |=> (count == 8'd0));
  // R8: a nonzero load appears in the counter and clears the flag
  p_load_lands_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && strb.loadVal != 8'd0) |=> (count == $past(strb.loadVal) && !expired));
  // R4: the flag rises together with the timeout pulse
  p_flag_pulse_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(expired) |-> !timeoutN);
  // R7: keyboard reset is only low inside a timeout pulse
  p_kbd_in_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    !kbdRstN |-> !timeoutN);
endmodule

// File: rtl/sec_watchdog.sv
module sec_watchdog
  import wdt_pkg::*;
#(
  parameter int unsigned CLKS_PER_SEC = 32768,
  parameter int unsigned PULSE_CLKS   = 16,
  parameter logic [7:0]  TMO_ADDR     = 8'hF6,
  parameter logic [7:0]  CTL_ADDR     = 8'hF5,
  parameter logic [7:0]  STS_ADDR     = 8'hF7
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWr,
  input  logic [7:0] regAddr,
  input  logic [7:0] regWdata,
  output logic [7:0] regRdata,
  input  logic       kbdEvent,
  input  logic       mouseEvent,
  output logic       timeoutN,
  output logic       kbdRstN
);
  wdtStrobe_t strb;
  logic [7:0] count;
  logic       expired;

  wdt_ctrl #(.TMO_ADDR(TMO_ADDR), .CTL_ADDR(CTL_ADDR), .STS_ADDR(STS_ADDR)) i_ctrl (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .kbdEvent(kbdEvent), .mouseEvent(mouseEvent),
    .countIn(count), .expiredIn(expired), .strb(strb)
  );

  wdt_datapath #(.CLKS_PER_SEC(CLKS_PER_SEC), .PULSE_CLKS(PULSE_CLKS)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .count(count), .expired(expired),
    .timeoutN(timeoutN), .kbdRstN(kbdRstN)
  );
endmodule

// File: tb/test_sec_watchdog.sv
module test_sec_watchdog;
  localparam int CLK_PERIOD = 10;
  localparam int CPS   = 10;
  localparam int PULSE = 4;
  localparam logic [7:0] A_TMO = 8'hF6, A_CTL = 8'hF5, A_STS = 8'hF7;

  logic clk = 0, rstN = 0, regWr = 0, kbdEvent = 0, mouseEvent = 0;
  logic [7:0] regAddr = 0, regWdata = 0, regRdata;
  logic timeoutN, kbdRstN;

  int cyc = 0, errors = 0, checks = 0;

  typedef struct { int at; bit kbdLow; string tag; } expItem_t;
  expItem_t sbq[$];

  sec_watchdog #(.CLKS_PER_SEC(CPS), .PULSE_CLKS(PULSE)) i_sec_watchdog (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .kbdEvent(kbdEvent), .mouseEvent(mouseEvent),
    .timeoutN(timeoutN), .kbdRstN(kbdRstN)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d, output int w);
    @(negedge clk); regWr = 1; regAddr = a; regWdata = d;
    @(negedge clk); regWr = 0; w = cyc;
  endtask

  task automatic rd(input logic [7:0] a, output int v);
    regAddr = a; #1 v = int'(regRdata);
  endtask

  task automatic kbd(output int e);
    @(negedge clk); kbdEvent = 1; @(negedge clk); kbdEvent = 0; e = cyc;
  endtask

  task automatic mouse(output int e);
    @(negedge clk); mouseEvent = 1; @(negedge clk); mouseEvent = 0; e = cyc;
  endtask

  task automatic waitc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expectPulse(int at, bit kbdLow, string tag);
    expItem_t it;
    it.at = at; it.kbdLow = kbdLow; it.tag = tag;
    sbq.push_back(it);
  endtask

  // Monitor: pops expected expiries as pulses start, measures widths
  bit prevN = 1;
  int lowCnt = 0;
  always @(negedge clk) begin
    if (rstN) begin
      if (prevN && !timeoutN) begin
        if (sbq.size() == 0) begin
          checks++; errors++;
          $display("FAIL R3: unexpected pulse actual=cycle %0d expected=none", cyc);
        end else begin
          expItem_t it;
          it = sbq.pop_front();
          check({it.tag, " expiry cycle"}, cyc, it.at);
          check("R7 keyboard reset level", int'(!kbdRstN), int'(it.kbdLow));
        end
      end
      if (!timeoutN) lowCnt++;
      else if (lowCnt != 0) begin
        check("R5 pulse width", lowCnt, PULSE);
        lowCnt = 0;
      end
      prevN = timeoutN;
    end
  end

  always @(posedge clk) if (cyc > 150000) begin
    checks++; errors++;
    $display("FAIL watchdog: actual=cycle %0d expected=finish", cyc);
    finishRun();
  end

  initial begin
    int w, e, v;
    waitc(3); rstN = 1; waitc(1);
    // R1 reset state
    rd(A_TMO, v); check("R1 counter", v, 0);
    rd(A_CTL, v); check("R1 control", v, 0);
    rd(A_STS, v); check("R1 status", v, 0);
    check("R1 timeoutN", int'(timeoutN), 1);
    check("R1 kbdRstN", int'(kbdRstN), 1);
    // R12 other address / readback
    rd(8'h00, v); check("R12 unmapped read", v, 0);

    // R2/R4 basic countdown, no keyboard routing
    wr(A_TMO, 8'd3, w); expectPulse(w + 3*CPS, 0, "R4");
    rd(A_TMO, v); check("R2 count after load", v, 3);
    waitc(15); rd(A_TMO, v); check("R2 remaining", v, 2);
    waitc(25); rd(A_TMO, v); check("R4 counter stays 0", v, 0);
    rd(A_STS, v); check("R4 status flag", v, 8'h10);
    // R6 write 1 does not set, write 0 clears
    wr(A_STS, 8'h10, w); rd(A_STS, v); check("R6 write 1 keeps set", v, 8'h10);
    wr(A_STS, 8'h00, w); rd(A_STS, v); check("R6 cleared by write 0", v, 0);
    wr(A_STS, 8'h10, w); rd(A_STS, v); check("R6 write 1 does not set", v, 0);

    // R7 routing to keyboard reset
    wr(A_CTL, 8'h02, w);
    wr(A_TMO, 8'd2, w); expectPulse(w + 2*CPS, 1, "R7");
    waitc(30);
    rd(A_STS, v); check("R4 flag after routed expiry", v, 8'h10);
    wr(A_TMO, 8'd5, w); rd(A_STS, v); check("R6 cleared by nonzero load", v, 0);
    // R3 stop
    waitc(12); wr(A_TMO, 8'd0, w);
    rd(A_TMO, v); check("R3 stopped count", v, 0);
    waitc(70); rd(A_TMO, v); check("R3 still stopped", v, 0);
    wr(A_CTL, 8'h00, w);

    // R8 keepalive
    wr(A_TMO, 8'd3, w); waitc(25);
    wr(A_TMO, 8'd3, w); expectPulse(w + 3*CPS, 0, "R8");
    rd(A_TMO, v); check("R8 reloaded count", v, 3);
    waitc(40);

    // R9 minute units
    wr(A_CTL, 8'h08, w);
    wr(A_TMO, 8'd1, w); expectPulse(w + 60*CPS, 0, "R9");
    waitc(300); rd(A_TMO, v); check("R9 count after 30 s", v, 1);
    waitc(310);
    wr(A_CTL, 8'h0A, w); rd(A_CTL, v); check("R12 control readback", v, 8'h0A);
    wr(A_CTL, 8'h00, w);

    // R10 keyboard reload enabled, mouse disabled
    wr(A_STS, 8'h40, w); rd(A_STS, v); check("R10 kbd enable readback", v, 8'h40);
    wr(A_TMO, 8'd2, w); waitc(14);
    kbd(e); expectPulse(e + 2*CPS, 0, "R10 kbd");
    rd(A_TMO, v); check("R10 kbd reload value", v, 2);
    waitc(4); mouse(w);
    waitc(25);
    // R10 mouse reload enabled
    wr(A_STS, 8'h80, w);
    wr(A_TMO, 8'd2, w); waitc(14);
    mouse(e); expectPulse(e + 2*CPS, 0, "R10 mouse");
    waitc(4); kbd(w);
    waitc(25);
    // R10 both disabled
    wr(A_STS, 8'h00, w);
    wr(A_TMO, 8'd2, w); expectPulse(w + 2*CPS, 0, "R10 disabled");
    waitc(10); kbd(e); mouse(e);
    waitc(15);

    // R11 keyboard stop beats reload
    wr(A_CTL, 8'h04, w); wr(A_STS, 8'h40, w);
    wr(A_TMO, 8'd3, w); waitc(12);
    kbd(e); rd(A_TMO, v); check("R11 keyboard stop", v, 0);
    waitc(40); rd(A_TMO, v); check("R11 stays stopped", v, 0);

    waitc(5);
    check("scoreboard drained", sbq.size(), 0);
    finishRun();
  end
endmodule